// File: doc/BRIEF.md
# Dual-Timing Multiplexed Host Bus Port

This block connects an 8-bit host bus that carries both address and data on the same wires to an internal register file. A strap input selects how three shared control pins are read. With the strap low they are a read strobe, an address latch enable and a write strobe, in the separate-strobe style. With the strap high they are a data strobe, an address strobe and a read/write direction level, in the single-strobe style. The strap is sampled continuously, so the pins are reinterpreted at runtime whenever it changes.

Every host input is first brought into the system clock through a synchronizer chain. A rising edge on the address latch/strobe pin captures the bus as the register address. While a read is active and chip select is low, the block enables its bus drivers and returns the register file's read data. When a write completes, it produces a single-cycle internal write enable with the latched address and the bus data. The register contents are held outside this block.

Top module: `hostbus_port`

## Requirements
- R1: During and directly after reset, `ad_oe`, `reg_re` and `reg_we` are 0 and `reg_addr` is 0.
- R2: A rising edge on `ale_as` loads the value on `ad_in` into `reg_addr`, in both strap settings, whatever the state of `cs_n`. `reg_addr` changes at no other time.
- R3: With the strap low (`bus_type_moto`=0), `cs_n`=0 and `rd_ds_n`=0, the block asserts `ad_oe` and `reg_re` and drives `ad_out` with `reg_rdata`. Both enables drop once `rd_ds_n` returns high.
- R4: With the strap low and `cs_n`=0, a rising edge on `wr_rw` produces one `reg_we` pulse of exactly one cycle. The pulse carries `reg_addr` and the `ad_in` value present at that edge in `reg_wdata`.
- R5: With the strap high, `cs_n`=0, `rd_ds_n`=0 and `wr_rw`=1 (1 means read), the block asserts `ad_oe` and `reg_re` and drives `ad_out` with `reg_rdata`. The enables drop when `rd_ds_n` rises.
- R6: With the strap high and `cs_n`=0, a rising edge on `rd_ds_n` while `wr_rw`=0 produces one single-cycle `reg_we` pulse that carries the latched address and the bus data.
- R7: While `cs_n` is high, no strobe activity asserts `ad_oe`, `reg_re` or `reg_we`.
- R8: With the strap high, a data strobe with `wr_rw`=0 never enables the bus drivers.
- R9: With the strap high, a low-then-high pulse on `wr_rw` while `rd_ds_n` stays high produces no write.
- R10: Each output reacts three clock cycles after its cause appears on the pins: two synchronizer stages and one output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_type_moto | input | 1 | Strap: 0 selects separate read/write strobes, 1 selects data strobe plus direction level |
| cs_n | input | 1 | Chip select, active low |
| ale_as | input | 1 | Address latch enable / address strobe; a rising edge captures the address |
| rd_ds_n | input | 1 | Read strobe (strap 0) or data strobe (strap 1), active low |
| wr_rw | input | 1 | Write strobe, active low (strap 0), or direction, 1 = read (strap 1) |
| ad_in | input | 8 | Multiplexed address/data bus, input side |
| ad_out | output | 8 | Bus read data, valid while ad_oe is 1, otherwise 0 |
| ad_oe | output | 1 | Bus driver enable |
| reg_addr | output | 8 | Latched register address |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | Single-cycle register write enable |
| reg_re | output | 1 | Register read enable, high while a read is active |
| reg_rdata | input | 8 | Read data from the register file for reg_addr |

## Verification
Writes and reads are run under both strap settings, each at several addresses and data values. An address-dependent read-data function shows whether the captured address, and not a stale one, reaches the register file. Writes are repeated with chip select high, with the direction level set to write during a data strobe, and with a lone pulse on the direction pin. These tell apart a decode that follows the strap from one that hard-wires either timing style or ignores chip select. A scoreboard pairs every write pulse with the expected address and data, so missing, extra and stretched pulses are all caught.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

    typedef struct packed {
        logic moto;     // strap: 1 = data strobe + direction timing
        logic cs_n;     // chip select, active low
        logic stb;      // address latch / address strobe
        logic rd_ds_n;  // read strobe or data strobe
        logic wr_rw;    // write strobe or direction level
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{moto: 1'b0, cs_n: 1'b1, stb: 1'b0,
                                  rd_ds_n: 1'b1, wr_rw: 1'b1};

    typedef enum logic [1:0] {ACC_IDLE, ACC_READ, ACC_WRITE} acc_e;

    // Access type implied by the current pin levels.
    function automatic acc_e level_access(ctl_t c);
        acc_e a;
        a = ACC_IDLE;
        if (!c.cs_n) begin
            if (c.moto) begin
                if (!c.rd_ds_n) a = c.wr_rw ? ACC_READ : ACC_WRITE;
            end else begin
                if (!c.rd_ds_n)    a = ACC_READ;
                else if (!c.wr_rw) a = ACC_WRITE;
            end
        end
        return a;
    endfunction

    // Edge that completes a write cycle.
    function automatic logic write_commit(ctl_t prev, ctl_t cur);
        logic hit;
        if (cur.moto)
            hit = !prev.rd_ds_n && cur.rd_ds_n && !cur.wr_rw;
        else
            hit = !prev.wr_rw && cur.wr_rw;
        return hit && !cur.cs_n;
    endfunction

endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[g] <= RST_VAL;
                else     stage[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[g] <= RST_VAL;
                else     stage[g] <= stage[g-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/hbp_decode.sv
module hbp_decode
    import hbp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t cur,
    output logic read_lvl,
    output logic commit,
    output logic stb_rise
);
    ctl_t prev;
    acc_e acc;

    always_ff @(posedge clk) begin
        if (rst) prev <= CTL_IDLE;
        else     prev <= cur;
    end

    always_comb begin
        acc      = level_access(cur);
        read_lvl = (acc == ACC_READ);
        commit   = write_commit(prev, cur);
        stb_rise = cur.stb && !prev.stb;
    end
endmodule

// File: rtl/hostbus_port.sv
module hostbus_port
    import hbp_pkg::*;
#(
    parameter int DW = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_type_moto,
    input  logic          cs_n,
    input  logic          ale_as,
    input  logic          rd_ds_n,
    input  logic          wr_rw,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic [DW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_we,
    output logic          reg_re,
    input  logic [DW-1:0] reg_rdata
);
    localparam int CW = $bits(ctl_t);

    ctl_t          ctl_raw, ctl_s;
    logic [DW-1:0] ad_s;
    logic          read_lvl, commit, stb_rise;
    logic          rd_q;

    always_comb begin
        ctl_raw.moto    = bus_type_moto;
        ctl_raw.cs_n    = cs_n;
        ctl_raw.stb     = ale_as;
        ctl_raw.rd_ds_n = rd_ds_n;
        ctl_raw.wr_rw   = wr_rw;
    end

    hbp_sync #(.W(CW), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync_ctl (
        .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s)
    );

    hbp_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_ad (
        .clk(clk), .rst(rst), .d(ad_in), .q(ad_s)
    );

    hbp_decode u_dec (
        .clk(clk), .rst(rst), .cur(ctl_s),
        .read_lvl(read_lvl), .commit(commit), .stb_rise(stb_rise)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_we    <= 1'b0;
            rd_q      <= 1'b0;
        end else begin
            if (stb_rise) reg_addr <= ad_s;
            if (commit)   reg_wdata <= ad_s;
            reg_we <= commit;
            rd_q   <= read_lvl;
        end
    end

    assign ad_oe  = rd_q;
    assign reg_re = rd_q;
    assign ad_out = rd_q ? reg_rdata : '0;
endmodule

// File: rtl/hbp_checker.sv
module hbp_checker #(
    parameter int DW = 8,
    parameter int SYNC_STAGES = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_type_moto,
    input logic          cs_n,
    input logic          ale_as,
    input logic          wr_rw,
    input logic          ad_oe,
    input logic          reg_we,
    input logic          reg_re,
    input logic [DW-1:0] reg_addr
);
    localparam int LAT = SYNC_STAGES + 1;

    // R4 / R6: the write enable never lasts two cycles
    a_r4_we_single: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    // R7: a write pulse needs chip select low at its cause
    a_r7_we_needs_cs: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> !$past(cs_n, LAT));

    // R7: bus drive needs chip select low
    a_r7_oe_needs_cs: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> !$past(cs_n, LAT));

    // R2: the address changes only after an address strobe
    a_r2_addr_on_strobe: assert property (@(posedge clk) disable iff (rst)
        !$stable(reg_addr) |-> $past(ale_as, LAT));

    // R6 / R8: in strobe+direction timing a write needs direction = write
    a_r6_moto_write_dir: assert property (@(posedge clk) disable iff (rst)
        (reg_we && $past(bus_type_moto, LAT)) |-> !$past(wr_rw, LAT));

    // R3 / R5: read enable and bus enable go together
    a_r3_re_with_oe: assert property (@(posedge clk) disable iff (rst)
        reg_re |-> ad_oe);
endmodule

bind hostbus_port hbp_checker #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk(clk), .rst(rst), .bus_type_moto(bus_type_moto), .cs_n(cs_n),
    .ale_as(ale_as), .wr_rw(wr_rw), .ad_oe(ad_oe), .reg_we(reg_we),
    .reg_re(reg_re), .reg_addr(reg_addr)
);

// File: tb/sim_hostbus_port.sv
module sim_hostbus_port;
    localparam int DW = 8;
    localparam int LIMIT = 200000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_type_moto = 1'b0, cs_n = 1'b1, ale_as = 1'b0;
    logic rd_ds_n = 1'b1, wr_rw = 1'b1;
    logic [DW-1:0] ad_in = '0;
    logic [DW-1:0] ad_out, reg_addr, reg_wdata, reg_rdata;
    logic ad_oe, reg_we, reg_re;

    int n_cmp = 0, n_bad = 0, we_seen = 0, pushed = 0;
    logic [2*DW-1:0] exp_q [$];

    always #5 clk = ~clk;

    // register file model: read data is a function of the address
    assign reg_rdata = reg_addr ^ 8'hA5;

    hostbus_port #(.DW(DW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .bus_type_moto(bus_type_moto), .cs_n(cs_n),
        .ale_as(ale_as), .rd_ds_n(rd_ds_n), .wr_rw(wr_rw), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
        .reg_rdata(reg_rdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: each write pulse is matched against the expected queue (R4, R6)
    always @(negedge clk) begin
        if (!rst && reg_we) begin
            we_seen++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7/R9 unexpected write", {reg_addr, reg_wdata}, 0);
            end else begin
                logic [2*DW-1:0] e;
                e = exp_q.pop_front();
                chk({reg_addr, reg_wdata} == e, "R4/R6 write", {reg_addr, reg_wdata}, e);
            end
        end
    end

    task automatic addr_phase(input logic [DW-1:0] a);
        ad_in = a; ale_as = 1'b1;
        idle(3);
        ale_as = 1'b0;
        idle(3);
        chk(reg_addr == a, "R2 address latch", reg_addr, a);
    endtask

    task automatic intel_write(input logic [DW-1:0] a, input logic [DW-1:0] d, input logic sel);
        addr_phase(a);
        cs_n = sel; ad_in = d; wr_rw = 1'b0;
        idle(4);
        if (!sel) begin exp_q.push_back({a, d}); pushed++; end
        chk(ad_oe == 1'b0, "R4 no drive during write", ad_oe, 0);
        wr_rw = 1'b1;
        idle(5);
        cs_n = 1'b1;
        idle(2);
    endtask

    task automatic intel_read(input logic [DW-1:0] a, input logic sel);
        addr_phase(a);
        cs_n = sel; rd_ds_n = 1'b0;
        idle(5);
        if (!sel) begin
            chk(ad_oe && reg_re, "R3 read enables", {ad_oe, reg_re}, 3);
            chk(ad_out == (a ^ 8'hA5), "R3 read data", ad_out, a ^ 8'hA5);
        end else begin
            chk(!ad_oe && !reg_re, "R7 read ignored with cs high", {ad_oe, reg_re}, 0);
        end
        rd_ds_n = 1'b1;
        idle(5);
        chk(!ad_oe && !reg_re, "R3 release", {ad_oe, reg_re}, 0);
        cs_n = 1'b1;
        idle(2);
    endtask

    task automatic moto_write(input logic [DW-1:0] a, input logic [DW-1:0] d, input logic sel);
        addr_phase(a);
        cs_n = sel; wr_rw = 1'b0; ad_in = d; rd_ds_n = 1'b0;
        idle(4);
        chk(ad_oe == 1'b0, "R8 no drive for write direction", ad_oe, 0);
        if (!sel) begin exp_q.push_back({a, d}); pushed++; end
        rd_ds_n = 1'b1;
        idle(5);
        cs_n = 1'b1; wr_rw = 1'b1;
        idle(2);
    endtask

    task automatic moto_read(input logic [DW-1:0] a);
        addr_phase(a);
        cs_n = 1'b0; wr_rw = 1'b1; rd_ds_n = 1'b0;
        idle(5);
        chk(ad_oe && reg_re, "R5 read enables", {ad_oe, reg_re}, 3);
        chk(ad_out == (a ^ 8'hA5), "R5 read data", ad_out, a ^ 8'hA5);
        rd_ds_n = 1'b1;
        idle(5);
        chk(!ad_oe && !reg_re, "R5 release", {ad_oe, reg_re}, 0);
        cs_n = 1'b1;
        idle(2);
    endtask

    task automatic run_all();
        int base;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!ad_oe && !reg_re && !reg_we, "R1 enables after reset", {ad_oe, reg_re, reg_we}, 0);
        chk(reg_addr == '0, "R1 address after reset", reg_addr, 0);

        // R10: latency of the bus enable is three cycles
        addr_phase(8'h3C);
        cs_n = 1'b0; rd_ds_n = 1'b0;
        idle(2);
        chk(ad_oe == 1'b0, "R10 enable not yet", ad_oe, 0);
        idle(1);
        chk(ad_oe == 1'b1, "R10 enable after three cycles", ad_oe, 1);
        rd_ds_n = 1'b1; cs_n = 1'b1;
        idle(5);

        // separate-strobe timing (R3, R4)
        intel_write(8'h12, 8'h34, 1'b0);
        intel_write(8'hFF, 8'h00, 1'b0);
        intel_write(8'h00, 8'hFF, 1'b0);
        intel_read(8'h5A, 1'b0);
        intel_read(8'hC3, 1'b0);
        // R7: chip select high
        base = we_seen;
        intel_write(8'h77, 8'h88, 1'b1);
        chk(we_seen == base, "R7 write ignored with cs high", we_seen - base, 0);
        intel_read(8'h66, 1'b1);

        // strobe + direction timing (R5, R6, R8, R9)
        bus_type_moto = 1'b1;
        idle(4);
        moto_write(8'hA1, 8'h5E, 1'b0);
        moto_write(8'h01, 8'h80, 1'b0);
        moto_read(8'h9B);
        moto_read(8'h24);
        base = we_seen;
        moto_write(8'h44, 8'h99, 1'b1);
        chk(we_seen == base, "R7 strobe write ignored with cs high", we_seen - base, 0);
        // R9: direction pin pulse alone
        base = we_seen;
        addr_phase(8'hE7);
        cs_n = 1'b0; ad_in = 8'h11; wr_rw = 1'b0;
        idle(4);
        wr_rw = 1'b1;
        idle(5);
        cs_n = 1'b1;
        chk(we_seen == base, "R9 direction pulse gives no write", we_seen - base, 0);
        chk(ad_oe == 1'b0, "R9 no drive", ad_oe, 0);

        // back to separate strobes: R2 latch with cs high still works
        bus_type_moto = 1'b0;
        idle(4);
        addr_phase(8'hB4);
        intel_write(8'h2D, 8'hD2, 1'b0);
        idle(4);
        chk(exp_q.size() == 0, "R4/R6 all writes seen", exp_q.size(), 0);
        chk(we_seen == pushed, "R4/R6 pulse count", we_seen, pushed);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (LIMIT) @(posedge clk);
                chk(1'b0, "watchdog", 0, 1);
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule